// File: doc/BRIEF.md
# Virtual performance-control register bank

This block gives each virtual CPU of a guest a private, identically laid out register region in one contiguous address window. Through a simple two-phase APB-style port the guest reads the CPU's present performance level and asks for a new one. It also walks the CPU's list of permitted performance points through an indexed select/read window and learns which performance domain the CPU shares with others. All performance values are normalized integers, with 1024 as the fastest point of the whole machine.

The host side supplies the live data as flat vectors: present performance, point-list length, point-list contents and domain number for every CPU. Each accepted performance request is legalized against that CPU's point list. It is then handed to the host as a one-cycle strobe that carries the CPU index and the legalized value. The bus side follows a three-state sequencer. ST_IDLE moves to ST_SETUP on a setup phase (select high, enable low). ST_SETUP moves to ST_ACCESS on an enable phase, and that enable cycle is the only cycle in which a transfer takes effect. It stays in ST_SETUP on a repeated setup phase and falls back to ST_IDLE otherwise. ST_ACCESS returns to ST_SETUP on a new setup phase and to ST_IDLE otherwise.

Top module: `vperf_regbank`

## Requirements
- R1: After reset the request strobe is low, every CPU's table-select register reads 0, and read data is 0.
- R2: Offset 0x00 of a region returns that CPU's host-supplied present performance; writes to it change nothing and raise no strobe.
- R3: CPU n's region starts at byte address n*0x20. Offsets other than 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14, and every region at or beyond the CPU count, read as 0 and ignore writes. The strobe's CPU index is always below the CPU count.
- R4: Offset 0x08 returns the host-supplied point-list length and offset 0x14 the host-supplied domain number of that CPU.
- R5: A write to offset 0x0C stores a 32-bit index that reads back unchanged from 0x0C; offset 0x10 then returns the point-list entry at that index.
- R6: If the stored index is at or beyond the usable length (the host length, capped at MAXPTS), offset 0x10 returns 0.
- R7: A write to offset 0x04 of a present CPU raises the request strobe for exactly the one cycle after the enable cycle, with that CPU's index and the legalized value.
- R8: With a length of 0 or 1 there is no discrete list: entry 0 is the maximum, and a request is clamped into 1..maximum.
- R9: With a length of 2 or more (entries ascending), a request becomes the first entry not below it, or the last usable entry if every entry is below it.
- R10: A transfer takes effect only in an enable phase that directly follows a setup phase; read data is 0 in every other cycle.
- R11: Each CPU's table-select register is private; writing one leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus enable (second phase) |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address in the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the enable cycle |
| host_cur | input | NCPU*32 | Present performance per CPU |
| host_len | input | NCPU*32 | Point-list length per CPU |
| host_tbl | input | NCPU*MAXPTS*32 | Point-list entries per CPU, entry 0 lowest |
| host_dom | input | NCPU*32 | Domain number per CPU |
| req_valid | output | 1 | One-cycle request strobe |
| req_cpu | output | ADDR_W-5 | CPU index of the request |
| req_perf | output | 32 | Legalized requested performance |

## Verification
A performance request is legalized against the host's point list in the same enable cycle in which the host may be rewriting that list. The bench provokes this by changing one entry of a CPU's list in the very cycle that carries the enable phase of a request write to that CPU. It then expects the strobe to carry the value legalized against the new list. The behavioural model in the bench predicts every strobe cycle, index and value, and it is compared against the outputs on every clock, so a strobe that is late, lost or resolved against stale entries is caught.

// File: rtl/vperf_pkg.sv
package vperf_pkg;
    localparam int DW          = 32;
    localparam int REGION_BITS = 5;   // 0x20-byte stride per CPU

    localparam logic [REGION_BITS-1:0] OFS_CUR = 5'h00;
    localparam logic [REGION_BITS-1:0] OFS_SET = 5'h04;
    localparam logic [REGION_BITS-1:0] OFS_LEN = 5'h08;
    localparam logic [REGION_BITS-1:0] OFS_SEL = 5'h0C;
    localparam logic [REGION_BITS-1:0] OFS_TBL = 5'h10;
    localparam logic [REGION_BITS-1:0] OFS_DOM = 5'h14;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACCESS
    } bus_state_e;
endpackage

// File: rtl/vperf_resolve.sv
module vperf_resolve
    import vperf_pkg::*;
#(
    parameter int MAXPTS = 8
) (
    input  logic [DW-1:0]        want,
    input  logic [DW-1:0]        len,
    input  logic [MAXPTS*DW-1:0] tbl,
    output logic [DW-1:0]        got
);
    localparam int IW = (MAXPTS > 1) ? $clog2(MAXPTS) : 1;

    logic [DW-1:0] ent [MAXPTS];
    logic [DW-1:0] lim;
    logic [IW-1:0] last_idx;
    logic          found;

    for (genvar g = 0; g < MAXPTS; g++) begin : g_ent
        assign ent[g] = tbl[g*DW +: DW];
    end

    always_comb begin
        lim      = (len > DW'(MAXPTS)) ? DW'(MAXPTS) : len;
        last_idx = IW'(lim - 1);
        found    = 1'b0;
        got      = '0;
        if (len <= 1) begin
            // single entry is the ceiling, floor is 1
            if (want < 1)
                got = 1;
            else if (want > ent[0])
                got = ent[0];
            else
                got = want;
        end else begin
            got = ent[last_idx];
            for (int i = 0; i < MAXPTS; i++) begin
                if (!found && (DW'(i) < lim) && (ent[i] >= want)) begin
                    got   = ent[i];
                    found = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/vperf_slot.sv
module vperf_slot
    import vperf_pkg::*;
#(
    parameter int MAXPTS = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sel_we,
    input  logic [DW-1:0]          wdata,
    input  logic [REGION_BITS-1:0] offs,
    input  logic [DW-1:0]          cur,
    input  logic [DW-1:0]          len,
    input  logic [MAXPTS*DW-1:0]   tbl,
    input  logic [DW-1:0]          dom,
    output logic [DW-1:0]          rdata
);
    localparam int IW = (MAXPTS > 1) ? $clog2(MAXPTS) : 1;

    logic [DW-1:0] sel_q;
    logic [DW-1:0] ent [MAXPTS];
    logic [DW-1:0] lim;
    logic [DW-1:0] win;

    for (genvar g = 0; g < MAXPTS; g++) begin : g_ent
        assign ent[g] = tbl[g*DW +: DW];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (sel_we)
            sel_q <= wdata;
    end

    always_comb begin
        lim = (len > DW'(MAXPTS)) ? DW'(MAXPTS) : len;
        win = (sel_q < lim) ? ent[sel_q[IW-1:0]] : '0;
    end

    always_comb begin
        unique case (offs)
            OFS_CUR: rdata = cur;
            OFS_LEN: rdata = len;
            OFS_SEL: rdata = sel_q;
            OFS_TBL: rdata = win;
            OFS_DOM: rdata = dom;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/vperf_regbank.sv
module vperf_regbank
    import vperf_pkg::*;
#(
    parameter int NCPU   = 3,
    parameter int MAXPTS = 8,
    parameter int ADDR_W = $clog2(NCPU) + 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     psel,
    input  logic                     penable,
    input  logic                     pwrite,
    input  logic [ADDR_W-1:0]        paddr,
    input  logic [31:0]              pwdata,
    output logic [31:0]              prdata,
    input  logic [NCPU*32-1:0]       host_cur,
    input  logic [NCPU*32-1:0]       host_len,
    input  logic [NCPU*MAXPTS*32-1:0] host_tbl,
    input  logic [NCPU*32-1:0]       host_dom,
    output logic                     req_valid,
    output logic [ADDR_W-6:0]        req_cpu,
    output logic [31:0]              req_perf
);
    localparam int CPU_W  = ADDR_W - REGION_BITS;
    localparam int TBL_W  = MAXPTS * DW;

    bus_state_e state_q, state_d;

    logic                   commit;
    logic [CPU_W-1:0]       cpu_idx;
    logic [REGION_BITS-1:0] offs;
    logic                   hit;
    logic [DW-1:0]          slot_rd [NCPU];
    logic [DW-1:0]          rd_pick;
    logic [TBL_W-1:0]       tbl_pick;
    logic [DW-1:0]          len_pick;
    logic [DW-1:0]          legal;

    assign cpu_idx = paddr[ADDR_W-1:REGION_BITS];
    assign offs    = paddr[REGION_BITS-1:0];
    assign hit     = (32'(cpu_idx) < 32'(NCPU));
    assign commit  = (state_q == ST_SETUP) && psel && penable;

    // ---------------- bus sequencer: state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // ---------------- bus sequencer: next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = (psel && !penable) ? ST_SETUP : ST_IDLE;
            ST_SETUP: begin
                if (psel && penable)
                    state_d = ST_ACCESS;
                else if (psel)
                    state_d = ST_SETUP;
                else
                    state_d = ST_IDLE;
            end
            ST_ACCESS: state_d = (psel && !penable) ? ST_SETUP : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // ---------------- per-CPU regions ----------------
    for (genvar g = 0; g < NCPU; g++) begin : g_cpu
        logic we_sel;
        assign we_sel = commit && pwrite && hit && (cpu_idx == CPU_W'(g)) &&
                        (offs == OFS_SEL);
        vperf_slot #(.MAXPTS(MAXPTS)) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .sel_we(we_sel),
            .wdata (pwdata),
            .offs  (offs),
            .cur   (host_cur[g*DW +: DW]),
            .len   (host_len[g*DW +: DW]),
            .tbl   (host_tbl[g*TBL_W +: TBL_W]),
            .dom   (host_dom[g*DW +: DW]),
            .rdata (slot_rd[g])
        );
    end

    always_comb begin
        rd_pick  = '0;
        tbl_pick = '0;
        len_pick = '0;
        for (int k = 0; k < NCPU; k++) begin
            if (cpu_idx == CPU_W'(k)) begin
                rd_pick  = slot_rd[k];
                tbl_pick = host_tbl[k*TBL_W +: TBL_W];
                len_pick = host_len[k*DW +: DW];
            end
        end
    end

    // one legalizer shared by all CPUs, fed through the address mux
    vperf_resolve #(.MAXPTS(MAXPTS)) u_resolve (
        .want(pwdata),
        .len (len_pick),
        .tbl (tbl_pick),
        .got (legal)
    );

    // ---------------- outputs ----------------
    assign prdata = (commit && !pwrite && hit) ? rd_pick : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid <= 1'b0;
            req_cpu   <= '0;
            req_perf  <= '0;
        end else begin
            req_valid <= commit && pwrite && hit && (offs == OFS_SET);
            if (commit && pwrite && hit && (offs == OFS_SET)) begin
                req_cpu  <= cpu_idx;
                req_perf <= legal;
            end
        end
    end

    // ---------------- assertions ----------------
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);                                            // R7
    AST_STROBE_CPU_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (32'(req_cpu) < 32'(NCPU)));                            // R3
    AST_STROBE_AFTER_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $past(psel && penable && pwrite));                      // R10
    AST_NOLIST_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ($past(len_pick) <= 1)) |->
        ((req_perf >= 1) && (req_perf <= $past(tbl_pick[DW-1:0]))));          // R8
    AST_LIST_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ($past(len_pick) > 1) &&
         ($past(pwdata) <= $past(tbl_pick[DW-1:0]))) |->
        (req_perf == $past(tbl_pick[DW-1:0])));                               // R9
endmodule

// File: tb/sim_vperf_regbank.sv
module sim_vperf_regbank;
    localparam int NCPU   = 3;
    localparam int MAXPTS = 8;
    localparam int ADDR_W = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [ADDR_W-1:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [NCPU*32-1:0] host_cur, host_len, host_dom;
    logic [NCPU*MAXPTS*32-1:0] host_tbl;
    logic req_valid;
    logic [ADDR_W-6:0] req_cpu;
    logic [31:0] req_perf;

    int unsigned h_cur [NCPU];
    int unsigned h_len [NCPU];
    int unsigned h_dom [NCPU];
    int unsigned h_tbl [NCPU][MAXPTS];
    int unsigned m_sel [NCPU];

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    bit done = 0;

    int    q_cpu[$];
    int    q_val[$];
    int    q_due[$];
    string q_tag[$];

    always #2 clk = ~clk;   // 250 MHz

    always_comb begin
        for (int c = 0; c < NCPU; c++) begin
            host_cur[c*32 +: 32] = h_cur[c];
            host_len[c*32 +: 32] = h_len[c];
            host_dom[c*32 +: 32] = h_dom[c];
            for (int e = 0; e < MAXPTS; e++)
                host_tbl[(c*MAXPTS+e)*32 +: 32] = h_tbl[c][e];
        end
    end

    vperf_regbank #(.NCPU(NCPU), .MAXPTS(MAXPTS), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .host_cur(host_cur), .host_len(host_len), .host_tbl(host_tbl),
        .host_dom(host_dom), .req_valid(req_valid), .req_cpu(req_cpu),
        .req_perf(req_perf)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural legalizer from R8/R9
    function automatic int unsigned ref_legal(input int c, input int unsigned v);
        int unsigned n;
        n = h_len[c];
        if (n <= 1) begin
            if (v < 1) return 1;
            if (v > h_tbl[c][0]) return h_tbl[c][0];
            return v;
        end
        if (n > MAXPTS) n = MAXPTS;
        for (int i = 0; i < int'(n); i++)
            if (h_tbl[c][i] >= v) return h_tbl[c][i];
        return h_tbl[c][n-1];
    endfunction

    // behavioural read model from R2..R6
    function automatic int unsigned ref_read(input int addr);
        int c, o;
        int unsigned n;
        c = addr / 32;
        o = addr % 32;
        if (c >= NCPU) return 0;
        case (o)
            'h00: return h_cur[c];
            'h08: return h_len[c];
            'h0C: return m_sel[c];
            'h10: begin
                n = (h_len[c] > MAXPTS) ? MAXPTS : h_len[c];
                return (m_sel[c] < n) ? h_tbl[c][m_sel[c]] : 0;
            end
            'h14: return h_dom[c];
            default: return 0;
        endcase
    endfunction

    function automatic void model_write(input int addr, input int unsigned data, input string tag);
        int c, o;
        c = addr / 32;
        o = addr % 32;
        if (c >= NCPU) return;
        if (o == 'h0C) m_sel[c] = data;
        if (o == 'h04) begin
            q_cpu.push_back(c);
            q_val.push_back(int'(ref_legal(c, data)));
            q_due.push_back(cyc + 1);
            q_tag.push_back(tag);
        end
    endfunction

    task automatic apb_wr(input int addr, input int unsigned data, input string tag);
        @(posedge clk); #1;
        psel = 1; penable = 0; pwrite = 1; paddr = addr[ADDR_W-1:0]; pwdata = data;
        @(posedge clk); #1;
        penable = 1;
        model_write(addr, data, tag);
        @(posedge clk); #1;
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input int addr, input string tag);
        @(posedge clk); #1;
        psel = 1; penable = 0; pwrite = 0; paddr = addr[ADDR_W-1:0];
        @(negedge clk);
        check("R10 setup-phase prdata", prdata, 0);
        @(posedge clk); #1;
        penable = 1;
        @(negedge clk);
        check(tag, prdata, ref_read(addr));
        @(posedge clk); #1;
        psel = 0; penable = 0;
    endtask

    // every-clock comparison of the request strobe against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (q_due.size() > 0 && q_due[0] == cyc) begin
                check({q_tag[0], " R7 strobe"}, req_valid, 1);
                check({q_tag[0], " R7 cpu"}, req_cpu, q_cpu[0]);
                check({q_tag[0], " value"}, req_perf, q_val[0]);
                void'(q_cpu.pop_front());
                void'(q_val.pop_front());
                void'(q_due.pop_front());
                void'(q_tag.pop_front());
            end else begin
                check("R7 idle strobe", req_valid, 0);
            end
        end
    end

    always @(posedge clk) cyc <= cyc + 1;

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        #400000;
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        // CPU0: no list, max 425; CPU1: 4 ascending points; CPU2: length 10, capped to 8
        h_cur = '{300, 768, 1024};
        h_len = '{1, 4, 10};
        h_dom = '{5, 5, 9};
        for (int c = 0; c < NCPU; c++)
            for (int e = 0; e < MAXPTS; e++)
                h_tbl[c][e] = 0;
        h_tbl[0][0] = 425;
        h_tbl[1][0] = 256; h_tbl[1][1] = 512; h_tbl[1][2] = 768; h_tbl[1][3] = 1024;
        for (int e = 0; e < MAXPTS; e++) h_tbl[2][e] = 128 * (e + 1);
        m_sel = '{0, 0, 0};

        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check("R1 strobe after reset", req_valid, 0);
        check("R1 prdata after reset", prdata, 0);
        apb_rd('h0C, "R1 select reset cpu0");
        apb_rd('h4C, "R1 select reset cpu2");

        apb_rd('h00, "R2 cur cpu0");
        apb_rd('h20, "R2 cur cpu1");
        apb_rd('h40, "R2 cur cpu2");
        apb_wr('h00, 99, "R2");
        apb_rd('h00, "R2 cur after write");

        apb_rd('h08, "R4 len cpu0");
        apb_rd('h48, "R4 len cpu2");
        apb_rd('h14, "R4 dom cpu0");
        apb_rd('h34, "R4 dom cpu1");
        apb_rd('h54, "R4 dom cpu2");

        apb_wr('h2C, 2, "R5");
        apb_rd('h2C, "R5 select readback");
        apb_rd('h30, "R5 window cpu1 idx2");
        apb_rd('h10, "R5 window cpu0 idx0");
        apb_rd('h4C, "R11 cpu2 select untouched");
        apb_wr('h2C, 4, "R6");
        apb_rd('h30, "R6 window at length");
        apb_wr('h4C, 7, "R6");
        apb_rd('h50, "R6 window last capped entry");
        apb_wr('h4C, 8, "R6");
        apb_rd('h50, "R6 window beyond cap");
        apb_wr('h4C, 32'hFFFF_FFFF, "R6");
        apb_rd('h50, "R6 window huge index");

        apb_wr('h04, 0,    "R8 zero");
        apb_wr('h04, 300,  "R8 inside");
        apb_wr('h04, 425,  "R8 at max");
        apb_wr('h04, 1000, "R8 above max");
        apb_wr('h24, 100,  "R9 below first");
        apb_wr('h24, 256,  "R9 exact");
        apb_wr('h24, 513,  "R9 round up");
        apb_wr('h24, 2000, "R9 above top");
        apb_wr('h44, 1100, "R9 capped list top");
        apb_wr('h44, 129,  "R9 capped list mid");

        // R3: unused offsets and absent region
        apb_rd('h18, "R3 unused offset");
        apb_rd('h06, "R3 misaligned offset");
        apb_rd('h60, "R3 absent region");
        apb_wr('h18, 55, "R3");
        apb_wr('h64, 700, "R3 absent set");
        apb_wr('h6C, 3, "R3");
        apb_rd('h0C, "R3 select unchanged");

        // R10: enable phase with no setup phase before it
        @(posedge clk); #1;
        psel = 1; penable = 1; pwrite = 1; paddr = 7'h2C; pwdata = 1;
        @(posedge clk); #1;
        paddr = 7'h24; pwdata = 900;
        @(posedge clk); #1;
        psel = 0; penable = 0; pwrite = 0;
        apb_rd('h2C, "R10 select not written");

        // list rewritten by the host in the enable cycle of a request
        @(posedge clk); #1;
        psel = 1; penable = 0; pwrite = 1; paddr = 7'h24; pwdata = 300;
        @(posedge clk); #1;
        penable = 1;
        h_tbl[1][1] = 320;
        model_write('h24, 300, "R9 concurrent list update");
        @(posedge clk); #1;
        psel = 0; penable = 0; pwrite = 0;

        // back-to-back transfers without an idle cycle
        @(posedge clk); #1;
        psel = 1; penable = 0; pwrite = 1; paddr = 7'h04; pwdata = 50;
        @(posedge clk); #1;
        penable = 1;
        model_write('h04, 50, "R7 back-to-back first");
        @(posedge clk); #1;
        penable = 0; paddr = 7'h44; pwdata = 640;
        @(posedge clk); #1;
        penable = 1;
        model_write('h44, 640, "R7 back-to-back second");
        @(posedge clk); #1;
        psel = 0; penable = 0; pwrite = 0;

        repeat (4) @(posedge clk);
        check("R7 all strobes seen", q_due.size(), 0);
        @(negedge clk);
        finish_run();
    end
endmodule